// File: doc/BRIEF.md
# Decoupled Stream Prefetch Engine

The engine takes one memory access pattern, described once before a loop starts, and fetches the data elements of that pattern on its own. Fetched elements wait in a small in-order buffer ahead of the core, so the loop body does not compute addresses or wait for loads. The pattern is affine, with addresses formed from a base plus a fixed stride per iteration. It can also be indirect: each element's address is built from the value the affine pattern returned for the same iteration, scaled by a shift and added to a second base address.

The core sees the element at its current iteration through a read port that acts as a pseudo-register. It moves to the next iteration with a step command. Steps are speculative until the core commits them. A step taken on a mispredicted path is undone by moving the iteration back, and the buffered data stays where it is. A checkpoint command saves the speculative position, and a restore command returns to it. A flush discards everything after the committed position and fetches it again. An end command releases the stream. A faulting fetch is held with its element and is reported only when the core reads that element.

Requests leave on a request/response port that carries a tag. The responder returns the tag unchanged, so responses may arrive in any order.

Top module: `sp_stream_engine`

## Requirements
- R1: While reset is held and after it is released, req_valid, rd_ready and rd_first stay low until a configure command arrives.
- R2: A configure command (cmd_op 1) loads the base, stride and length and starts fetching. Affine element i is read from base + i*stride. The element at the current iteration appears on rd_data, with rd_ready high, once its response has returned.
- R3: With indirect mode enabled at configure, element i is the word at ind_base + (A_i << shift), where A_i is the value the affine fetch returned for iteration i. Each iteration then makes two requests: the affine one first, and the indirect one after the affine data returns.
- R4: The number of elements requested but not yet committed never exceeds DEPTH. Fetching resumes only as commits free entries.
- R5: No affine request is made for an iteration at or beyond the configured length. Once the final element has been stepped past, rd_ready is low.
- R6: A step (cmd_op 2) moves the current iteration forward by one. An undo (cmd_op 3) moves it back by one, but never below the committed iteration. After an undo, the earlier element is visible again in the next cycle, and no new request is made for it. A commit (cmd_op 4) retires the oldest stepped-past element and frees its entry.
- R7: A checkpoint (cmd_op 5) saves the current iteration. A restore (cmd_op 6) returns to that saved iteration, or to the committed iteration if the saved one has already been committed. The buffered elements are kept and are visible in the next cycle.
- R8: A fault returned with a response is stored with that element. rd_fault is high only while the core reads that element, and low on reads of every other element.
- R9: rd_first pulses on the first cycle with rd_valid and rd_ready both high after a configure, step, undo, restore or flush. It stays low on later reads of the same element.
- R10: An end command (cmd_op 0) deactivates the stream. From the next cycle, req_valid and rd_ready are low, and late responses are ignored.
- R11: A flush (cmd_op 7) drops all buffered and pending elements at or after the committed iteration and fetches them again. The current iteration is kept. Responses to requests made before the flush are ignored.
- R12: While the element at the current iteration has not yet returned, rd_ready stays low and the consumer waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one command per cycle |
| cmd_op | input | 3 | Command code (0 end, 1 configure, 2 step, 3 undo, 4 commit, 5 checkpoint, 6 restore, 7 flush) |
| cfg_base | input | 32 | Affine base address |
| cfg_stride | input | 32 | Byte stride between affine elements (two's complement) |
| cfg_len | input | 8 | Number of iterations |
| cfg_ind_en | input | 1 | Enable indirect mode |
| cfg_ind_base | input | 32 | Base address of the indirect array |
| cfg_ind_shift | input | 2 | Left shift applied to the affine value |
| req_valid | output | 1 | Read request valid |
| req_ready | input | 1 | Memory accepts the request |
| req_addr | output | 32 | Request address |
| req_tag | output | 4 | Request tag {epoch, slot}; the responder returns it unchanged |
| rsp_valid | input | 1 | Response valid |
| rsp_tag | input | 4 | Tag of the request being answered |
| rsp_data | input | 32 | Response data |
| rsp_fault | input | 1 | The access faulted |
| rd_valid | input | 1 | The core reads the pseudo-register |
| rd_ready | output | 1 | Element at the current iteration is present |
| rd_data | output | 32 | Element at the current iteration |
| rd_fault | output | 1 | The element being read carries a fault |
| rd_first | output | 1 | This read is the ordering point of the element |

## Verification
On every cycle, the assertions check four things: the occupancy bound, that no fetch goes past the stream length, that the current iteration never falls below the committed one, and that nothing is requested or presented while the stream is inactive. The bench scenarios cover the rest. They compare element values against addresses the bench computes itself, including chained indirect values and a negative stride. They also show that undo and restore bring back earlier data with no new request, that a prefetched fault stays hidden until its element is read, that a flush refetches from the committed point, and that the first-read pulse behaves as described.

// File: rtl/sp_pkg.sv
// Shared types for the stream prefetch engine.
// Assumes: command codes are fixed by the core-side decoder.
package sp_pkg;
    typedef enum logic [2:0] {
        OP_END     = 3'd0,
        OP_CFG     = 3'd1,
        OP_STEP    = 3'd2,
        OP_UNDO    = 3'd3,
        OP_COMMIT  = 3'd4,
        OP_CKPT    = 3'd5,
        OP_RESTORE = 3'd6,
        OP_FLUSH   = 3'd7
    } sp_op_e;

    // Life cycle of one buffer entry.
    typedef enum logic [2:0] {
        SL_EMPTY   = 3'd0,  // free
        SL_WAIT_B  = 3'd1,  // affine request outstanding
        SL_BASE_OK = 3'd2,  // affine value held, indirect request not yet made
        SL_WAIT_I  = 3'd3,  // indirect request outstanding
        SL_READY   = 3'd4,  // final element value held
        SL_DRAIN   = 3'd5   // retired while a response was still owed
    } slot_st_e;
endpackage

// File: rtl/sp_iter_ctl.sv
// Iteration bookkeeping: committed, speculative, issue and indirect
// positions, checkpoint, epoch and activity. All positions are absolute
// iteration numbers; the buffer slot is the low bits of the position.
// Assumes: at most one command per cycle; requests are squashed by the
// issue selector in cycles with configure, end, flush or commit.
module sp_iter_ctl #(
    parameter int LEN_W   = 8,
    parameter int DEPTH   = 4,
    parameter int EPOCH_W = 2,
    localparam int SLOT_W = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    input  sp_pkg::sp_op_e      cmd_op,
    input  logic [LEN_W-1:0]    cfg_len,
    input  logic                aff_fire,
    input  logic                ind_adv,
    input  logic                rd_fire,
    output logic                active,
    output logic [LEN_W-1:0]    len_q,
    output logic [EPOCH_W-1:0]  epoch,
    output logic [LEN_W-1:0]    commit_iter,
    output logic [LEN_W-1:0]    spec_iter,
    output logic [LEN_W-1:0]    issue_iter,
    output logic [LEN_W-1:0]    ind_iter,
    output logic                touched,
    output logic                clr_all,
    output logic                free_en,
    output logic [SLOT_W-1:0]   free_idx
);
    import sp_pkg::*;

    logic               active_n, touched_n;
    logic [LEN_W-1:0]   len_n, commit_n, spec_n, issue_n, ind_n, ckpt_q, ckpt_n;
    logic [EPOCH_W-1:0] epoch_n;
    logic               do_commit;

    assign do_commit = cmd_valid && (cmd_op == OP_COMMIT) && (spec_iter != commit_iter);
    assign clr_all   = cmd_valid && (cmd_op == OP_CFG || cmd_op == OP_END || cmd_op == OP_FLUSH);
    assign free_en   = do_commit && (commit_iter != issue_iter);
    assign free_idx  = commit_iter[SLOT_W-1:0];

    // Next-state selection for positions and stream status.
    always_comb begin
        active_n  = active;
        len_n     = len_q;
        epoch_n   = epoch;
        commit_n  = commit_iter;
        spec_n    = spec_iter;
        issue_n   = issue_iter + (aff_fire ? LEN_W'(1) : '0);
        ind_n     = ind_iter + (ind_adv ? LEN_W'(1) : '0);
        ckpt_n    = ckpt_q;
        touched_n = touched | rd_fire;
        if (cmd_valid) begin
            case (cmd_op)
                OP_CFG, OP_END: begin
                    active_n  = (cmd_op == OP_CFG);
                    len_n     = (cmd_op == OP_CFG) ? cfg_len : '0;
                    epoch_n   = epoch + EPOCH_W'(1);
                    commit_n  = '0;
                    spec_n    = '0;
                    issue_n   = '0;
                    ind_n     = '0;
                    ckpt_n    = '0;
                    touched_n = 1'b0;
                end
                OP_FLUSH: begin
                    epoch_n   = epoch + EPOCH_W'(1);
                    issue_n   = commit_iter;
                    ind_n     = commit_iter;
                    touched_n = 1'b0;
                end
                OP_STEP: begin
                    if (spec_iter < len_q) begin
                        spec_n    = spec_iter + LEN_W'(1);
                        touched_n = 1'b0;
                    end
                end
                OP_UNDO: begin
                    if (spec_iter != commit_iter) begin
                        spec_n    = spec_iter - LEN_W'(1);
                        touched_n = 1'b0;
                    end
                end
                OP_COMMIT: begin
                    if (do_commit) begin
                        commit_n = commit_iter + LEN_W'(1);
                        if (commit_iter == issue_iter) issue_n = issue_iter + LEN_W'(1);
                        if (ind_iter == commit_iter)   ind_n   = ind_iter + LEN_W'(1);
                    end
                end
                OP_CKPT: ckpt_n = spec_iter;
                OP_RESTORE: begin
                    spec_n    = (ckpt_q > commit_iter) ? ckpt_q : commit_iter;
                    touched_n = 1'b0;
                end
                default: ;
            endcase
        end
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active      <= 1'b0;
            len_q       <= '0;
            epoch       <= '0;
            commit_iter <= '0;
            spec_iter   <= '0;
            issue_iter  <= '0;
            ind_iter    <= '0;
            ckpt_q      <= '0;
            touched     <= 1'b0;
        end else begin
            active      <= active_n;
            len_q       <= len_n;
            epoch       <= epoch_n;
            commit_iter <= commit_n;
            spec_iter   <= spec_n;
            issue_iter  <= issue_n;
            ind_iter    <= ind_n;
            ckpt_q      <= ckpt_n;
            touched     <= touched_n;
        end
    end

    assert_depth_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_iter - commit_iter) <= LEN_W'(DEPTH));
    assert_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
        issue_iter <= len_q);
    assert_spec_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
        spec_iter >= commit_iter);
endmodule

// File: rtl/sp_slot_store.sv
// Element buffer: per-slot state, data and fault flag. A slot is written by
// allocation (affine request), indirect issue, response and commit.
// Assumes: the controller never allocates or issues into a slot that is
// being freed in the same cycle.
module sp_slot_store #(
    parameter int DEPTH  = 4,
    parameter int DATA_W = 32,
    localparam int SLOT_W = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr_all,
    input  logic                ind_mode,
    input  logic                alloc_en,
    input  logic                ind_iss_en,
    input  logic [SLOT_W-1:0]   iss_idx,
    input  logic                rsp_en,
    input  logic [SLOT_W-1:0]   rsp_idx,
    input  logic [DATA_W-1:0]   rsp_data,
    input  logic                rsp_fault,
    input  logic                free_en,
    input  logic [SLOT_W-1:0]   free_idx,
    output sp_pkg::slot_st_e    st_o    [DEPTH],
    output logic [DATA_W-1:0]   data_o  [DEPTH],
    output logic                fault_o [DEPTH]
);
    import sp_pkg::*;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        slot_st_e            st_q;
        logic [DATA_W-1:0]   data_q;
        logic                fault_q;
        logic                waiting, rsp_take, free_hit, iss_hit;

        assign waiting  = (st_q == SL_WAIT_B) || (st_q == SL_WAIT_I);
        assign rsp_take = rsp_en && (rsp_idx == SLOT_W'(g)) && (waiting || st_q == SL_DRAIN);
        assign free_hit = free_en && (free_idx == SLOT_W'(g));
        assign iss_hit  = iss_idx == SLOT_W'(g);

        // Per-slot life-cycle update.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q    <= SL_EMPTY;
                data_q  <= '0;
                fault_q <= 1'b0;
            end else if (clr_all) begin
                st_q    <= SL_EMPTY;
                fault_q <= 1'b0;
            end else if (free_hit) begin
                st_q <= (waiting && !rsp_take) ? SL_DRAIN : SL_EMPTY;
            end else if (rsp_take) begin
                case (st_q)
                    SL_WAIT_B: begin
                        data_q  <= rsp_data;
                        fault_q <= rsp_fault;
                        st_q    <= (ind_mode && !rsp_fault) ? SL_BASE_OK : SL_READY;
                    end
                    SL_WAIT_I: begin
                        data_q  <= rsp_data;
                        fault_q <= rsp_fault;
                        st_q    <= SL_READY;
                    end
                    default: st_q <= SL_EMPTY;
                endcase
            end else if (alloc_en && iss_hit) begin
                st_q    <= SL_WAIT_B;
                fault_q <= 1'b0;
            end else if (ind_iss_en && iss_hit) begin
                st_q <= SL_WAIT_I;
            end
        end

        assign st_o[g]    = st_q;
        assign data_o[g]  = data_q;
        assign fault_o[g] = fault_q;
    end

    // A commit may only retire an entry that holds or awaits an element.
    assert_free_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        free_en |-> (st_o[free_idx] != SL_EMPTY));
endmodule

// File: rtl/sp_issue_sel.sv
// Request selection for the single memory port. An indirect request for the
// oldest iteration whose affine value has arrived goes first; otherwise the
// next affine iteration is requested if it is within length and room.
// Assumes: indirect requests are made in iteration order.
module sp_issue_sel #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int LEN_W  = 8,
    parameter int DEPTH  = 4,
    localparam int SLOT_W = $clog2(DEPTH)
) (
    input  logic                active,
    input  logic                ind_en,
    input  logic                squash,
    input  logic [LEN_W-1:0]    len_q,
    input  logic [LEN_W-1:0]    issue_iter,
    input  logic [LEN_W-1:0]    commit_iter,
    input  logic [LEN_W-1:0]    ind_iter,
    input  sp_pkg::slot_st_e    st      [DEPTH],
    input  logic [DATA_W-1:0]   data    [DEPTH],
    input  logic [ADDR_W-1:0]   base,
    input  logic [ADDR_W-1:0]   stride,
    input  logic [ADDR_W-1:0]   ind_base,
    input  logic [1:0]          shift,
    input  logic                req_ready,
    output logic                req_valid,
    output logic [ADDR_W-1:0]   req_addr,
    output logic [SLOT_W-1:0]   req_slot,
    output logic                aff_fire,
    output logic                ind_fire,
    output logic                ind_adv
);
    import sp_pkg::*;

    logic [SLOT_W-1:0] ind_slot, aff_slot;
    logic              ind_pend, ind_can, ind_skip, aff_can, fire;
    logic [ADDR_W-1:0] aff_addr, ind_addr;

    // Candidate evaluation and address formation.
    always_comb begin
        ind_slot = ind_iter[SLOT_W-1:0];
        aff_slot = issue_iter[SLOT_W-1:0];
        ind_pend = active && ind_en && (ind_iter != issue_iter);
        ind_can  = ind_pend && (st[ind_slot] == SL_BASE_OK);
        ind_skip = ind_pend && (st[ind_slot] == SL_READY) && !squash;
        aff_can  = active && (issue_iter < len_q)
                   && ((issue_iter - commit_iter) < LEN_W'(DEPTH))
                   && (st[aff_slot] == SL_EMPTY);
        aff_addr = base + ({{(ADDR_W-LEN_W){1'b0}}, issue_iter} * stride);
        ind_addr = ind_base + (ADDR_W'(data[ind_slot]) << shift);
    end

    assign req_valid = !squash && (ind_can || aff_can);
    assign req_addr  = ind_can ? ind_addr : aff_addr;
    assign req_slot  = ind_can ? ind_slot : aff_slot;
    assign fire      = req_valid && req_ready;
    assign ind_fire  = fire && ind_can;
    assign aff_fire  = fire && !ind_can;
    assign ind_adv   = ind_fire || ind_skip;
endmodule

// File: rtl/sp_stream_engine.sv
// Top of the stream prefetch engine: configuration registers, response
// acceptance, head-element presentation and wiring of the submodules.
// Assumes: the responder echoes req_tag on rsp_tag; rsp is always accepted.
module sp_stream_engine #(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int LEN_W   = 8,
    parameter int DEPTH   = 4,
    parameter int EPOCH_W = 2,
    localparam int SLOT_W = $clog2(DEPTH),
    localparam int TAG_W  = EPOCH_W + SLOT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic [2:0]         cmd_op,
    input  logic [ADDR_W-1:0]  cfg_base,
    input  logic [ADDR_W-1:0]  cfg_stride,
    input  logic [LEN_W-1:0]   cfg_len,
    input  logic               cfg_ind_en,
    input  logic [ADDR_W-1:0]  cfg_ind_base,
    input  logic [1:0]         cfg_ind_shift,
    output logic               req_valid,
    input  logic               req_ready,
    output logic [ADDR_W-1:0]  req_addr,
    output logic [TAG_W-1:0]   req_tag,
    input  logic               rsp_valid,
    input  logic [TAG_W-1:0]   rsp_tag,
    input  logic [DATA_W-1:0]  rsp_data,
    input  logic               rsp_fault,
    input  logic               rd_valid,
    output logic               rd_ready,
    output logic [DATA_W-1:0]  rd_data,
    output logic               rd_fault,
    output logic               rd_first
);
    import sp_pkg::*;

    sp_op_e             op;
    logic [ADDR_W-1:0]  base_q, stride_q, ind_base_q;
    logic               ind_en_q;
    logic [1:0]         shift_q;
    logic               active, touched, clr_all, free_en, squash;
    logic [LEN_W-1:0]   len_q, commit_iter, spec_iter, issue_iter, ind_iter;
    logic [EPOCH_W-1:0] epoch;
    logic [SLOT_W-1:0]  free_idx, req_slot, head;
    logic               aff_fire, ind_fire, ind_adv, rsp_ok, rd_fire;
    slot_st_e           st    [DEPTH];
    logic [DATA_W-1:0]  data  [DEPTH];
    logic               fault [DEPTH];

    assign op     = sp_op_e'(cmd_op);
    assign squash = cmd_valid && (op == OP_CFG || op == OP_END || op == OP_FLUSH || op == OP_COMMIT);

    // Capture the stream description on configure.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q     <= '0;
            stride_q   <= '0;
            ind_base_q <= '0;
            ind_en_q   <= 1'b0;
            shift_q    <= '0;
        end else if (cmd_valid && op == OP_CFG) begin
            base_q     <= cfg_base;
            stride_q   <= cfg_stride;
            ind_base_q <= cfg_ind_base;
            ind_en_q   <= cfg_ind_en;
            shift_q    <= cfg_ind_shift;
        end
    end

    sp_iter_ctl #(.LEN_W(LEN_W), .DEPTH(DEPTH), .EPOCH_W(EPOCH_W)) u_iter (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(op),
        .cfg_len(cfg_len), .aff_fire(aff_fire), .ind_adv(ind_adv), .rd_fire(rd_fire),
        .active(active), .len_q(len_q), .epoch(epoch), .commit_iter(commit_iter),
        .spec_iter(spec_iter), .issue_iter(issue_iter), .ind_iter(ind_iter),
        .touched(touched), .clr_all(clr_all), .free_en(free_en), .free_idx(free_idx)
    );

    sp_issue_sel #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W), .DEPTH(DEPTH)) u_sel (
        .active(active), .ind_en(ind_en_q), .squash(squash), .len_q(len_q),
        .issue_iter(issue_iter), .commit_iter(commit_iter), .ind_iter(ind_iter),
        .st(st), .data(data), .base(base_q), .stride(stride_q), .ind_base(ind_base_q),
        .shift(shift_q), .req_ready(req_ready), .req_valid(req_valid), .req_addr(req_addr),
        .req_slot(req_slot), .aff_fire(aff_fire), .ind_fire(ind_fire), .ind_adv(ind_adv)
    );

    // Responses count only for the current epoch of a live stream.
    assign rsp_ok  = rsp_valid && active && (rsp_tag[TAG_W-1 -: EPOCH_W] == epoch);
    assign req_tag = {epoch, req_slot};

    sp_slot_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst_n(rst_n), .clr_all(clr_all), .ind_mode(ind_en_q),
        .alloc_en(aff_fire), .ind_iss_en(ind_fire), .iss_idx(req_slot),
        .rsp_en(rsp_ok), .rsp_idx(rsp_tag[SLOT_W-1:0]), .rsp_data(rsp_data),
        .rsp_fault(rsp_fault), .free_en(free_en), .free_idx(free_idx),
        .st_o(st), .data_o(data), .fault_o(fault)
    );

    // Pseudo-register view of the element at the speculative iteration.
    assign head     = spec_iter[SLOT_W-1:0];
    assign rd_ready = active && (spec_iter < issue_iter) && (st[head] == SL_READY);
    assign rd_data  = data[head];
    assign rd_fire  = rd_valid && rd_ready;
    assign rd_fault = rd_fire && fault[head];
    assign rd_first = rd_fire && !touched;

    assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (!req_valid && !rd_ready));
    assert_no_head_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (spec_iter >= issue_iter) |-> !rd_ready);
    assert_first_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_first && !(cmd_valid && op != OP_CKPT && op != OP_COMMIT)) |=> !rd_first);
endmodule

// File: tb/sim_sp_stream_engine.sv
// Self-checking bench: table of stream configurations walked by one loop,
// then directed scenarios for reset, rollback, faults, flush and end.
module sim_sp_stream_engine;
    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = 3'd0;
    logic [31:0] cfg_base = '0, cfg_stride = '0, cfg_ind_base = '0;
    logic [7:0]  cfg_len = '0;
    logic        cfg_ind_en = 1'b0;
    logic [1:0]  cfg_ind_shift = '0;
    logic        req_valid, req_ready;
    logic [31:0] req_addr;
    logic [3:0]  req_tag;
    logic        rsp_valid = 1'b0;
    logic [3:0]  rsp_tag = '0;
    logic [31:0] rsp_data = '0;
    logic        rsp_fault = 1'b0;
    logic        rd_valid = 1'b1;
    logic        rd_ready, rd_fault, rd_first;
    logic [31:0] rd_data;
    logic        mem_rdy = 1'b1;
    logic [31:0] fault_addr = 32'hFFFF_FFF1;
    int          req_cnt = 0;
    int          checks = 0, fails = 0;

    always #2 clk = ~clk;  // 250 MHz

    sp_stream_engine u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cfg_base(cfg_base), .cfg_stride(cfg_stride), .cfg_len(cfg_len),
        .cfg_ind_en(cfg_ind_en), .cfg_ind_base(cfg_ind_base), .cfg_ind_shift(cfg_ind_shift),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_tag(req_tag),
        .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_data(rsp_data), .rsp_fault(rsp_fault),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
        .rd_fault(rd_fault), .rd_first(rd_first)
    );

    function automatic logic [31:0] mv(input logic [31:0] a);
        return a * 32'h0000_9E37 + 32'h0000_1234;
    endfunction

    function automatic logic [31:0] elem(input logic [31:0] b, input logic [31:0] s,
                                         input logic ind, input logic [31:0] ib,
                                         input logic [1:0] sh, input int i);
        logic [31:0] a;
        a = mv(b + 32'(i) * s);
        return ind ? mv(ib + (a << sh)) : a;
    endfunction

    // Memory model: one-cycle latency, tag echoed.
    assign req_ready = mem_rdy;
    always @(posedge clk) begin
        if (req_valid && req_ready) req_cnt++;
        rsp_valid <= req_valid && req_ready;
        rsp_tag   <= req_tag;
        rsp_data  <= mv(req_addr);
        rsp_fault <= (req_addr == fault_addr);
    end

    localparam logic [31:0] V_BASE  [4] = '{32'h400, 32'h1000, 32'h2000, 32'h3000};
    localparam logic [31:0] V_STR   [4] = '{32'h4, 32'h8, 32'hFFFF_FFFC, 32'h4};
    localparam logic [7:0]  V_LEN   [4] = '{8'd6, 8'd5, 8'd4, 8'd1};
    localparam logic        V_IND   [4] = '{1'b0, 1'b1, 1'b0, 1'b1};
    localparam logic [31:0] V_IBASE [4] = '{32'h0, 32'h8000, 32'h0, 32'h100};
    localparam logic [1:0]  V_SH    [4] = '{2'd0, 2'd2, 2'd0, 2'd0};

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [2:0] op);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic cfg(input logic [31:0] b, input logic [31:0] s, input logic [7:0] l,
                       input logic ind, input logic [31:0] ib, input logic [1:0] sh);
        cfg_base = b; cfg_stride = s; cfg_len = l;
        cfg_ind_en = ind; cfg_ind_base = ib; cfg_ind_shift = sh;
        send(3'd1);
    endtask

    task automatic wait_ready(input string tag);
        int n = 0;
        @(negedge clk);
        while (!rd_ready && n < 40) begin
            @(negedge clk);
            n++;
        end
        if (!rd_ready) chk(1'b0, tag, {31'd0, rd_ready}, 32'd1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int start;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(!req_valid && !rd_ready && !rd_first, "R1 outputs in reset", {req_valid, rd_ready, rd_first}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!req_valid && !rd_ready, "R1 idle after reset", {req_valid, rd_ready}, 0);

        // Table walk: R2, R3, R5
        for (int v = 0; v < 4; v++) begin
            start = req_cnt;
            cfg(V_BASE[v], V_STR[v], V_LEN[v], V_IND[v], V_IBASE[v], V_SH[v]);
            for (int i = 0; i < int'(V_LEN[v]); i++) begin
                logic [31:0] e;
                e = elem(V_BASE[v], V_STR[v], V_IND[v], V_IBASE[v], V_SH[v], i);
                wait_ready(V_IND[v] ? "R3 indirect ready" : "R2 affine ready");
                chk(rd_data == e, V_IND[v] ? "R3 indirect data" : "R2 affine data", rd_data, e);
                send(3'd2);
                send(3'd4);
            end
            repeat (4) @(negedge clk);
            chk(!rd_ready, "R5 nothing past length", {31'd0, rd_ready}, 0);
            chk((req_cnt - start) == int'(V_LEN[v]) * (V_IND[v] ? 2 : 1), "R5 request count",
                32'(req_cnt - start), 32'(int'(V_LEN[v]) * (V_IND[v] ? 2 : 1)));
            send(3'd0);
        end

        // R4: occupancy bound
        start = req_cnt;
        cfg(32'h5000, 32'h4, 8'd20, 1'b0, 32'h0, 2'd0);
        repeat (12) @(negedge clk);
        chk((req_cnt - start) == DEPTH, "R4 bounded prefetch", 32'(req_cnt - start), DEPTH);
        send(3'd2);
        send(3'd4);
        repeat (6) @(negedge clk);
        chk((req_cnt - start) == DEPTH + 1, "R4 refill after commit", 32'(req_cnt - start), DEPTH + 1);
        send(3'd0);

        // R12: consumer stalls while memory holds off
        mem_rdy = 1'b0;
        cfg(32'h900, 32'h4, 8'd3, 1'b0, 32'h0, 2'd0);
        repeat (5) @(negedge clk);
        chk(!rd_ready, "R12 not ready before data", {31'd0, rd_ready}, 0);
        chk(req_valid, "R12 request pending", {31'd0, req_valid}, 1);
        mem_rdy = 1'b1;
        wait_ready("R12 ready after data");
        chk(rd_data == mv(32'h900), "R12 data after stall", rd_data, mv(32'h900));
        send(3'd0);

        // R6: undo keeps buffered data
        cfg(32'h400, 32'h4, 8'd8, 1'b0, 32'h0, 2'd0);
        wait_ready("R6 first ready");
        send(3'd2);
        wait_ready("R6 stepped ready");
        chk(rd_data == mv(32'h404), "R6 step data", rd_data, mv(32'h404));
        start = req_cnt;
        send(3'd3);
        chk(rd_ready && rd_data == mv(32'h400), "R6 undo data", rd_data, mv(32'h400));
        chk(req_cnt == start, "R6 no refetch", 32'(req_cnt), 32'(start));

        // R7: checkpoint and restore
        send(3'd5);
        send(3'd2);
        send(3'd2);
        wait_ready("R7 ahead ready");
        chk(rd_data == mv(32'h408), "R7 ahead data", rd_data, mv(32'h408));
        send(3'd6);
        chk(rd_ready && rd_data == mv(32'h400), "R7 restore data", rd_data, mv(32'h400));

        // R11: flush refetches from committed point
        send(3'd2);
        send(3'd4);
        send(3'd2);
        send(3'd7);
        chk(!rd_ready, "R11 cleared by flush", {31'd0, rd_ready}, 0);
        wait_ready("R11 refetch ready");
        chk(rd_data == mv(32'h408), "R11 refetch data", rd_data, mv(32'h408));

        // R10: end releases the stream
        send(3'd0);
        chk(!rd_ready && !req_valid, "R10 idle after end", {rd_ready, req_valid}, 0);
        repeat (3) @(negedge clk);
        chk(!rd_ready && !req_valid, "R10 stays idle", {rd_ready, req_valid}, 0);

        // R9: first-read pulse
        rd_valid = 1'b0;
        cfg(32'h600, 32'h4, 8'd4, 1'b0, 32'h0, 2'd0);
        repeat (6) @(negedge clk);
        chk(rd_ready && !rd_first, "R9 no pulse without read", {rd_ready, rd_first}, 32'd2);
        rd_valid = 1'b1;
        #1;
        chk(rd_first, "R9 pulse on first read", {31'd0, rd_first}, 1);
        @(negedge clk);
        chk(!rd_first, "R9 no pulse on reread", {31'd0, rd_first}, 0);
        send(3'd2);
        chk(rd_first, "R9 pulse after step", {31'd0, rd_first}, 1);
        send(3'd0);

        // R8: fault held until its element is read
        fault_addr = 32'h708;
        cfg(32'h700, 32'h4, 8'd4, 1'b0, 32'h0, 2'd0);
        for (int i = 0; i < 4; i++) begin
            wait_ready("R8 ready");
            chk(rd_fault == (i == 2), "R8 fault on consumed element", {31'd0, rd_fault}, {31'd0, i == 2});
            send(3'd2);
            send(3'd4);
        end
        send(3'd0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule